// File: doc/BRIEF.md
# Cache Maintenance Register Front End

This block sits between a register bus and the core of a banked, set-associative cache. Software reads a fixed geometry word from it. It also sets a way-enable level that can only rise, and sends single-shot ECC fault-injection commands to the cache. Flush-by-address writes become one request per cache line toward the cache core, which completes each request with an acknowledge.

There are two flush entry offsets. The first takes a full physical address. The second takes the address already shifted right by four bits, so that a 32-bit write can still reach a large physical space. The block rebuilds the address from either form and aligns it down to the start of its line. While a line request waits for its acknowledge, further flush writes are held off with the write-ready signal. Writes to other offsets continue to complete.

Top module: `cache_maint_regs`

## Requirements
- R1: Offset 0x000 reads, in its low 32 bits, bank count in bits 7:0, way count in bits 15:8, log2 of sets per bank in bits 23:16 and log2 of line bytes in bits 31:24 (defaults give 0x060A1004). Writes to it change nothing.
- R2: The way-enable level at offset 0x008 (bits 7:0) is 0 after reset. A write replaces it only when the new, clamped value is larger, so the level never falls.
- R3: A value written to the way-enable level that is above the way count minus one is stored as the way count minus one.
- R4: A write to offset 0x200 raises a flush request for the written address with its low six bits cleared. A narrow write (regWrWide low) supplies only the low 32 data bits, with the upper bits taken as zero.
- R5: A write to offset 0x240 raises a flush request for the low 32 data bits shifted left by four, with the low six bits cleared.
- R6: flushReq rises in the cycle after the write is accepted. It holds with flushAddr stable until flushAck is seen while it is high, and then it drops one cycle later. flushAck has no effect while no request is pending.
- R7: While flushReq is high, regWrReady is low for writes to 0x200 or 0x240. It stays high for every other offset.
- R8: A write to offset 0x040 whose 64-bit value is below 0xFF, or is from 0x10000 up to but not including 0x100FF, drives injValid high for exactly one cycle after acceptance. injBit then carries data bits 7:0 and injSel carries data bit 16.
- R9: An injection value outside the ranges in R8 produces no pulse. Offset 0x040 reads as zero.
- R10: After reset, flushReq and injValid are low. Offsets with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrValid | input | 1 | Write request |
| regWrReady | output | 1 | Write accepted at this edge when high together with regWrValid |
| regWrWide | input | 1 | 1: 64-bit write, 0: 32-bit write (upper data ignored) |
| regWrAddr | input | 12 | Write byte offset |
| regWrData | input | 64 | Write data |
| regRdAddr | input | 12 | Read byte offset |
| regRdData | output | 64 | Read data, combinational from regRdAddr |
| flushReq | output | 1 | Line flush request to the cache core |
| flushAddr | output | 64 | Line-aligned physical address of the request |
| flushAck | input | 1 | Cache core has taken the request |
| injValid | output | 1 | One-cycle injection command |
| injBit | output | 8 | Target bit selector of the command |
| injSel | output | 1 | Second selector of the command |

## Verification
Read data is combinational, so a way-enable update is visible on regRdData in the cycle right after the accepting edge. flushReq, flushAddr and injValid all appear one register stage after acceptance, and flushReq falls one stage after the acknowledge edge. The bench drives inputs on falling edges, waits for the accepting rising edge inside its write task, and compares on the following falling edge. This is exactly the cycle in which each of these results is due. The injection pulse is checked again one cycle later to show that it has ended, and stall checks are taken on the cycle before and the cycle of the acknowledge.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_GEOM         = 12'h000;
  localparam logic [OFS_W-1:0] OFS_WAYEN        = 12'h008;
  localparam logic [OFS_W-1:0] OFS_INJ          = 12'h040;
  localparam logic [OFS_W-1:0] OFS_FLUSH_FULL   = 12'h200;
  localparam logic [OFS_W-1:0] OFS_FLUSH_SHIFT  = 12'h240;
  localparam int unsigned INJ_SEL_BIT = 16;
  localparam logic [31:0] INJ_LO_LIMIT = 32'h0000_00FF;
  localparam logic [31:0] INJ_HI_BASE  = 32'h0001_0000;
  localparam logic [31:0] INJ_HI_LIMIT = 32'h0001_00FF;

  typedef struct packed {
    logic wayWr;
    logic injWr;
    logic flushWr;
    logic flushShifted;
  } cmrStrobe_t;
endpackage

// File: rtl/cmr_ctrl.sv
module cmr_ctrl
  import cmr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              wrValid,
  input  logic [OFS_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flushBusy,
  output logic              wrReady,
  output cmrStrobe_t        strobe
);
  logic isFlushOfs;
  logic accept;
  logic injInRange;
  logic [31:0] injLo;

  assign isFlushOfs = (wrAddr == OFS_FLUSH_FULL) || (wrAddr == OFS_FLUSH_SHIFT);
  assign wrReady    = !(isFlushOfs && flushBusy);
  assign accept     = wrValid && wrReady;

  assign injLo      = wrData[31:0];
  assign injInRange = (wrData[DATA_W-1:32] == '0) &&
                      ((injLo < INJ_LO_LIMIT) ||
                       ((injLo >= INJ_HI_BASE) && (injLo < INJ_HI_LIMIT)));

  always_comb begin
    strobe              = '0;
    strobe.wayWr        = accept && (wrAddr == OFS_WAYEN);
    strobe.injWr        = accept && (wrAddr == OFS_INJ) && injInRange;
    strobe.flushWr      = accept && isFlushOfs;
    strobe.flushShifted = (wrAddr == OFS_FLUSH_SHIFT);
  end
endmodule

// File: rtl/cmr_datapath.sv
module cmr_datapath
  import cmr_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned BANKS        = 4,
  parameter int unsigned WAYS         = 16,
  parameter int unsigned LOG2_SETS    = 10,
  parameter int unsigned LINE_BYTES   = 64,
  parameter int unsigned NARROW_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [OFS_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              flushAck,
  output logic              flushReq,
  output logic [DATA_W-1:0] flushAddr,
  output logic              injValid,
  output logic [7:0]        injBit,
  output logic              injSel,
  output logic [7:0]        wayEn
);
  localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [7:0]  WAY_MAX  = 8'(WAYS - 1);
  localparam logic [DATA_W-1:0] LINE_MASK = ~(DATA_W'(LINE_BYTES - 1));
  localparam logic [31:0] GEOM_WORD =
    {8'(LINE_LSB), 8'(LOG2_SETS), 8'(WAYS), 8'(BANKS)};

  logic [7:0]        wayCand;
  logic [DATA_W-1:0] rebuilt;
  logic [DATA_W-1:0] lineAddr;

  assign wayCand  = (wrData[7:0] > WAY_MAX) ? WAY_MAX : wrData[7:0];
  assign rebuilt  = strobe.flushShifted ? (DATA_W'(wrData[31:0]) << NARROW_SHIFT) : wrData;
  assign lineAddr = rebuilt & LINE_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wayEn     <= '0;
      flushReq  <= 1'b0;
      flushAddr <= '0;
      injValid  <= 1'b0;
      injBit    <= '0;
      injSel    <= 1'b0;
    end else begin
      injValid <= strobe.injWr;
      if (strobe.injWr) begin
        injBit <= wrData[7:0];
        injSel <= wrData[INJ_SEL_BIT];
      end
      if (strobe.wayWr && (wayCand > wayEn)) wayEn <= wayCand;
      if (strobe.flushWr) begin
        flushReq  <= 1'b1;
        flushAddr <= lineAddr;
      end else if (flushReq && flushAck) begin
        flushReq <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_GEOM:  rdData = DATA_W'(GEOM_WORD);
      OFS_WAYEN: rdData = DATA_W'(wayEn);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/cache_maint_regs.sv
module cache_maint_regs
  import cmr_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned BANKS        = 4,
  parameter int unsigned WAYS         = 16,
  parameter int unsigned LOG2_SETS    = 10,
  parameter int unsigned LINE_BYTES   = 64,
  parameter int unsigned NARROW_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrValid,
  output logic              regWrReady,
  input  logic              regWrWide,
  input  logic [11:0]       regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [11:0]       regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              flushReq,
  output logic [DATA_W-1:0] flushAddr,
  input  logic              flushAck,
  output logic              injValid,
  output logic [7:0]        injBit,
  output logic              injSel
);
  cmrStrobe_t        strobe;
  logic [DATA_W-1:0] wrEff;
  logic [7:0]        wayEn;

  assign wrEff = regWrWide ? regWrData : {{(DATA_W-32){1'b0}}, regWrData[31:0]};

  cmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrValid   (regWrValid),
    .wrAddr    (regWrAddr),
    .wrData    (wrEff),
    .flushBusy (flushReq),
    .wrReady   (regWrReady),
    .strobe    (strobe)
  );

  cmr_datapath #(
    .DATA_W(DATA_W), .BANKS(BANKS), .WAYS(WAYS), .LOG2_SETS(LOG2_SETS),
    .LINE_BYTES(LINE_BYTES), .NARROW_SHIFT(NARROW_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrEff),
    .rdAddr    (regRdAddr),
    .rdData    (regRdData),
    .flushAck  (flushAck),
    .flushReq  (flushReq),
    .flushAddr (flushAddr),
    .injValid  (injValid),
    .injBit    (injBit),
    .injSel    (injSel),
    .wayEn     (wayEn)
  );
endmodule

// File: rtl/cmr_checker.sv
module cmr_checker
  import cmr_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WAYS       = 16,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrValid,
  input logic              regWrReady,
  input logic [11:0]       regWrAddr,
  input logic              flushReq,
  input logic [DATA_W-1:0] flushAddr,
  input logic              flushAck,
  input logic              injValid,
  input logic [7:0]        wayEn
);
  localparam logic [DATA_W-1:0] OFFSET_BITS = DATA_W'(LINE_BYTES - 1);

  // R6: pending request holds with a stable address
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !flushAck |=> flushReq && $stable(flushAddr));

  // R6: acknowledge releases the request
  a_r6_release_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && flushAck |=> !flushReq);

  // R7: flush offsets stall while busy
  a_r7_stall_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && regWrValid &&
    (regWrAddr == OFS_FLUSH_FULL || regWrAddr == OFS_FLUSH_SHIFT) |-> !regWrReady);

  // R4 / R5: requested address is line aligned
  a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (flushAddr & OFFSET_BITS) == '0);

  // R2: level never falls
  a_r2_never_lower: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> wayEn >= $past(wayEn));

  // R3: level stays within the way count
  a_r3_clamped: assert property (@(posedge clk) disable iff (!rstN)
    wayEn <= 8'(WAYS - 1));

  // R8: a pulse only follows an accepted write to the injection offset
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> $past(regWrValid && regWrReady && regWrAddr == OFS_INJ));
endmodule

bind cache_maint_regs cmr_checker #(
  .DATA_W(DATA_W), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)
) u_cmr_checker (
  .clk        (clk),
  .rstN       (rstN),
  .regWrValid (regWrValid),
  .regWrReady (regWrReady),
  .regWrAddr  (regWrAddr),
  .flushReq   (flushReq),
  .flushAddr  (flushAddr),
  .flushAck   (flushAck),
  .injValid   (injValid),
  .wayEn      (wayEn)
);

// File: tb/test_cache_maint_regs.sv
module test_cache_maint_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] GEOM_EXP = 64'h0000_0000_060A_1004;

  typedef struct packed {
    logic        wide;
    logic [11:0] wAddr;
    logic [63:0] wData;
    logic [11:0] rAddr;
    logic [63:0] rExp;
    logic        injExp;
    logic [7:0]  bitExp;
    logic        selExp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h008, 64'h5,                   12'h008, 64'h5,  1'b0, 8'h00, 1'b0}, // R2 raise
    '{1'b0, 12'h008, 64'h3,                   12'h008, 64'h5,  1'b0, 8'h00, 1'b0}, // R2 no lower
    '{1'b1, 12'h008, 64'hFFFF_FFFF_0000_000C, 12'h008, 64'hC,  1'b0, 8'h00, 1'b0}, // R2 low byte only
    '{1'b1, 12'h008, 64'd200,                 12'h008, 64'hF,  1'b0, 8'h00, 1'b0}, // R3 clamp
    '{1'b0, 12'h008, 64'h9,                   12'h008, 64'hF,  1'b0, 8'h00, 1'b0}, // R3 stays max
    '{1'b1, 12'h040, 64'h1_0005,              12'h040, 64'h0,  1'b1, 8'h05, 1'b1}, // R8 upper range
    '{1'b0, 12'h040, 64'hFE,                  12'h040, 64'h0,  1'b1, 8'hFE, 1'b0}, // R8 lower range edge
    '{1'b1, 12'h040, 64'hFF,                  12'h040, 64'h0,  1'b0, 8'h00, 1'b0}, // R9 limit excluded
    '{1'b1, 12'h040, 64'h1_00FF,              12'h040, 64'h0,  1'b0, 8'h00, 1'b0}, // R9 upper limit
    '{1'b1, 12'h040, 64'h100,                 12'h040, 64'h0,  1'b0, 8'h00, 1'b0}, // R9 gap
    '{1'b1, 12'h040, 64'h1_0001_0005,         12'h040, 64'h0,  1'b0, 8'h00, 1'b0}, // R9 upper word set
    '{1'b0, 12'h040, 64'h1_0001_0005,         12'h040, 64'h0,  1'b1, 8'h05, 1'b1}, // R8 narrow masks upper
    '{1'b1, 12'h000, 64'h1234,                12'h000, GEOM_EXP, 1'b0, 8'h00, 1'b0}, // R1 read only
    '{1'b1, 12'h100, 64'h7,                   12'h100, 64'h0,  1'b0, 8'h00, 1'b0}  // R10 unmapped
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrValid, regWrReady, regWrWide;
  logic [11:0] regWrAddr, regRdAddr;
  logic [63:0] regWrData, regRdData;
  logic        flushReq, flushAck;
  logic [63:0] flushAddr;
  logic        injValid, injSel;
  logic [7:0]  injBit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_maint_regs i_cache_maint_regs (
    .clk(clk), .rstN(rstN),
    .regWrValid(regWrValid), .regWrReady(regWrReady), .regWrWide(regWrWide),
    .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .flushReq(flushReq), .flushAddr(flushAddr), .flushAck(flushAck),
    .injValid(injValid), .injBit(injBit), .injSel(injSel)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, return at the falling edge after the accepting edge.
  task automatic doWrite(input logic wide, input logic [11:0] a, input logic [63:0] d);
    regWrValid = 1'b1; regWrWide = wide; regWrAddr = a; regWrData = d;
    #1;
    while (!regWrReady) begin @(negedge clk); #1; end
    @(negedge clk);
    regWrValid = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [11:0] a, input logic [63:0] exp);
    regRdAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrValid = 1'b0; regWrWide = 1'b0; regWrAddr = '0;
    regWrData = '0; regRdAddr = '0; flushAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check("R10 flushReq after reset", 64'(flushReq), 64'h0);
    check("R10 injValid after reset", 64'(injValid), 64'h0);
    readCheck("R2 way-enable reset", 12'h008, 64'h0);
    readCheck("R1 geometry word", 12'h000, GEOM_EXP);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].wide, VECS[i].wAddr, VECS[i].wData);
      check($sformatf("vec%0d injValid", i), 64'(injValid), 64'(VECS[i].injExp));
      if (VECS[i].injExp) begin
        check($sformatf("vec%0d injBit", i), 64'(injBit), 64'(VECS[i].bitExp));
        check($sformatf("vec%0d injSel", i), 64'(injSel), 64'(VECS[i].selExp));
      end
      readCheck($sformatf("vec%0d readback", i), VECS[i].rAddr, VECS[i].rExp);
    end

    // R8: pulse lasts one cycle
    doWrite(1'b1, 12'h040, 64'h1_0003);
    check("R8 pulse high", 64'(injValid), 64'h1);
    @(negedge clk);
    check("R8 pulse ended", 64'(injValid), 64'h0);

    // R6: acknowledge with nothing pending has no effect
    flushAck = 1'b1;
    @(negedge clk);
    flushAck = 1'b0;
    check("R6 stray ack", 64'(flushReq), 64'h0);

    // R4: full address flush
    doWrite(1'b1, 12'h200, 64'h0000_0012_3456_789F);
    check("R4 flushReq", 64'(flushReq), 64'h1);
    check("R4 flushAddr", flushAddr, 64'h0000_0012_3456_7880);

    // R7: second flush stalls while busy
    regWrValid = 1'b1; regWrWide = 1'b0; regWrAddr = 12'h240;
    regWrData = 64'hFFFF_0000_8765_4321;
    #1;
    check("R7 ready low while busy", 64'(regWrReady), 64'h0);
    @(negedge clk);
    check("R6 held without ack", 64'(flushReq), 64'h1);
    check("R6 address stable", flushAddr, 64'h0000_0012_3456_7880);
    flushAck = 1'b1;
    @(negedge clk);
    flushAck = 1'b0;
    check("R6 released after ack", 64'(flushReq), 64'h0);
    #1;
    check("R7 ready back", 64'(regWrReady), 64'h1);
    @(negedge clk);
    regWrValid = 1'b0;
    check("R5 flushReq", 64'(flushReq), 64'h1);
    check("R5 flushAddr", flushAddr, 64'h0000_0008_7654_3200);

    // R7: other offsets proceed while busy
    regWrAddr = 12'h040;
    #1;
    check("R7 ready for non-flush", 64'(regWrReady), 64'h1);
    doWrite(1'b1, 12'h040, 64'h7);
    check("R7 injection while busy", 64'(injValid), 64'h1);
    check("R5 still pending", 64'(flushReq), 64'h1);
    flushAck = 1'b1;
    @(negedge clk);
    flushAck = 1'b0;
    check("R6 second release", 64'(flushReq), 64'h0);

    // R4: narrow write to the full-address offset uses the low word only
    doWrite(1'b0, 12'h200, 64'hDEAD_BEEF_0000_1047);
    check("R4 narrow flushAddr", flushAddr, 64'h0000_0000_0000_1040);
    readCheck("R10 flush offset reads zero", 12'h200, 64'h0);
    flushAck = 1'b1;
    @(negedge clk);
    flushAck = 1'b0;
    check("R6 third release", 64'(flushReq), 64'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule